// File: doc/BRIEF.md
# Serial Configuration Register Slave for a Clock Synthesizer

This block is a two-wire serial slave that keeps six 8-bit control bytes for a system clock synthesizer and presents them in parallel to the clock core. A host updates the bytes with block writes. The command byte and the length byte of a write must be sent, but their values are dropped. The data bytes then fill the register file from byte 0 upward, and the host may stop after any complete byte. A block read returns a length byte followed by every register in ascending order.

SCL and SDA are sampled by the block's own clock through synchronizers. Start and stop conditions are detected from the synchronized levels. SDA is driven only by pulling it low through an open-drain enable. Byte 4 is not storage. It reflects the three power-on strap levels, inverted, so that software can see which frequency the hardware straps selected.

Top module: `cfgbus_i2c_slave`

## Requirements
- R1: Only the 7-bit device address 0x69 is acknowledged: 0xD2 for writes and 0xD3 for reads. Any other address is not acknowledged, and the slave leaves SDA alone until the next start.
- R2: In a write, the two bytes after the address (command, then length) are each acknowledged, and their values change no register.
- R3: Each data byte of a write is acknowledged and stored in order: the first at byte 0, the next at byte 1, and so on.
- R4: A stop after any complete data byte keeps the bytes already received, and the registers not yet reached keep their earlier values. Without a write, the writable bytes never change.
- R5: Data bytes beyond byte 5 are acknowledged but discarded. A data byte aimed at byte 4 is acknowledged but does not change it.
- R6: After reset, bytes 1, 2, 3 and 5 hold 0xFF and byte 0 holds 0x20. In byte 0 the software frequency code in bits {2,6,5,4} is 0010, the source-select bit 3 is 0, the spread bit 1 is 0, the tristate bit 0 is 0, and the spread-mode bit 7 is 0.
- R7: Byte 4 reads 1 in bits 7, 6, 4, 2 and 0. Bit 5 holds the inverted strap_i[2] (24/48 select), bit 3 the inverted strap_i[1] (FS1), and bit 1 the inverted strap_i[0] (FS3).
- R8: A read answers first with the length byte 6 and then with bytes 0 to 5, each sent MSB first. The slave changes SDA only while SCL is low.
- R9: A master not-acknowledge during a read ends the data phase. The slave releases SDA and stays off the bus until the next start.
- R10: A repeated start resets the byte pointer, so the data of the following write begins again at byte 0.
- R11: cfg_o carries byte n on bits [8n+7:8n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1, release when 0 |
| strap_i | input | 3 | Power-on straps: [2] 24/48 select, [1] FS1, [0] FS3 |
| cfg_o | output | NUM_REGS*8 | All register bytes in parallel, byte n at [8n+7:8n] |

## Verification
The bench builds the block with its default parameters: six registers, the read-only strap byte at index 4, two synchronizer stages and address 0x69. A bus quarter-bit lasts ten block clocks, so every SDA change made by the slave lands well inside the low phase of SCL. Because there are only six registers, an eight-byte write reaches the overflow path. A write aimed at byte 4 is set against the strap view, and changing the straps between transfers shows that byte 4 follows the pins both on cfg_o and in a read.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

   typedef enum logic [2:0] {
      BUS_IDLE   = 3'd0,
      BUS_RX     = 3'd1,
      BUS_RX_ACK = 3'd2,
      BUS_TX     = 3'd3,
      BUS_TX_ACK = 3'd4
   } bus_state_e;

   // Power-up value of a writable byte: byte 0 carries software code 0010
   // in bits {2,6,5,4} (bit 5 set), every other byte enables all outputs.
   function automatic logic [7:0] reset_byte(input int idx);
      return (idx == 0) ? 8'h20 : 8'hFF;
   endfunction

endpackage

// File: rtl/cfgbus_line_sync.sv
module cfgbus_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);

   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("cfgbus_line_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= 1'b1;
            else        chain <= line_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], line_i};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= chain[STAGES-1];
   end

   assign level_o = chain[STAGES-1];
   assign rise_o  = chain[STAGES-1] & ~prev;
   assign fall_o  = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/cfgbus_bus_fsm.sv
module cfgbus_bus_fsm
   import cfgbus_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h69,
   parameter int         NUM_REGS = 6,
   localparam int        IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
   localparam int        PTR_W    = $clog2(NUM_REGS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_lvl,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             sda_lvl,
   input  logic             sda_rise,
   input  logic             sda_fall,
   input  logic [7:0]       rd_data,
   output logic [IDX_W-1:0] rd_idx,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic [7:0]       wr_data,
   output logic             sda_oe,
   output bus_state_e       state_o
);

   localparam logic [PTR_W-1:0] PTR_END  = PTR_W'(NUM_REGS);
   localparam logic [7:0]       CNT_BYTE = 8'(NUM_REGS);

   bus_state_e       state;
   logic [3:0]       bit_cnt;
   logic [7:0]       shreg;
   logic             is_read;
   logic [1:0]       hdr;      // 0 addr, 1 command, 2 length, 3 data
   logic [PTR_W-1:0] ptr;
   logic             m_ack;
   logic [7:0]       nxt_tx;
   logic             start_c, stop_c;

   assign start_c = scl_lvl & sda_fall;
   assign stop_c  = scl_lvl & sda_rise;
   assign nxt_tx  = (ptr < PTR_END) ? rd_data : 8'hFF;
   assign rd_idx  = ptr[IDX_W-1:0];
   assign state_o = state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= BUS_IDLE;
         bit_cnt <= '0;
         shreg   <= '0;
         is_read <= 1'b0;
         hdr     <= '0;
         ptr     <= '0;
         m_ack   <= 1'b0;
         sda_oe  <= 1'b0;
         wr_en   <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_c) begin
            state   <= BUS_RX;
            bit_cnt <= '0;
            hdr     <= '0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
         end else if (stop_c) begin
            state  <= BUS_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               BUS_RX: begin
                  if (scl_rise) begin
                     shreg   <= {shreg[6:0], sda_lvl};
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall && bit_cnt == 4'd8) begin
                     if (hdr == 2'd0) begin
                        if (shreg[7:1] == DEV_ADDR) begin
                           sda_oe  <= 1'b1;
                           is_read <= shreg[0];
                           hdr     <= 2'd1;
                           state   <= BUS_RX_ACK;
                        end else begin
                           state <= BUS_IDLE;
                        end
                     end else begin
                        sda_oe <= 1'b1;
                        state  <= BUS_RX_ACK;
                        if (hdr != 2'd3) begin
                           hdr <= hdr + 2'd1;
                        end else if (ptr < PTR_END) begin
                           wr_en   <= 1'b1;
                           wr_idx  <= ptr[IDX_W-1:0];
                           wr_data <= shreg;
                           ptr     <= ptr + PTR_W'(1);
                        end
                     end
                  end
               end
               BUS_RX_ACK: begin
                  if (scl_fall) begin
                     bit_cnt <= '0;
                     if (is_read) begin
                        shreg  <= CNT_BYTE;
                        sda_oe <= ~CNT_BYTE[7];
                        state  <= BUS_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= BUS_RX;
                     end
                  end
               end
               BUS_TX: begin
                  if (scl_fall) begin
                     if (bit_cnt == 4'd7) begin
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                        state   <= BUS_TX_ACK;
                     end else begin
                        shreg   <= {shreg[6:0], 1'b0};
                        sda_oe  <= ~shreg[6];
                        bit_cnt <= bit_cnt + 4'd1;
                     end
                  end
               end
               BUS_TX_ACK: begin
                  if (scl_rise) begin
                     m_ack <= ~sda_lvl;
                  end else if (scl_fall) begin
                     if (m_ack) begin
                        shreg  <= nxt_tx;
                        sda_oe <= ~nxt_tx[7];
                        state  <= BUS_TX;
                        if (ptr < PTR_END) ptr <= ptr + PTR_W'(1);
                     end else begin
                        state <= BUS_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/cfgbus_reg_bank.sv
module cfgbus_reg_bank
   import cfgbus_pkg::*;
#(
   parameter int  NUM_REGS = 6,
   parameter int  RO_IDX   = 4,
   localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      wr_idx,
   input  logic [7:0]            wr_data,
   input  logic [IDX_W-1:0]      rd_idx,
   input  logic [2:0]            strap_i,
   output logic [7:0]            rd_data,
   output logic [NUM_REGS*8-1:0] cfg_o
);

   logic [7:0] view [NUM_REGS];

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
         if (g == RO_IDX) begin : g_strap
            assign view[g] = {2'b11, ~strap_i[2], 1'b1, ~strap_i[1], 1'b1, ~strap_i[0], 1'b1};
         end else begin : g_store
            logic [7:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                             q <= reset_byte(g);
               else if (wr_en && wr_idx == IDX_W'(g))  q <= wr_data;
            end
            assign view[g] = q;
         end
         assign cfg_o[g*8 +: 8] = view[g];
      end
   endgenerate

   assign rd_data = (int'(rd_idx) < NUM_REGS) ? view[rd_idx] : 8'hFF;

endmodule

// File: rtl/cfgbus_i2c_slave.sv
module cfgbus_i2c_slave
   import cfgbus_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h69,
   parameter int         NUM_REGS    = 6,
   parameter int         RO_IDX      = 4,
   parameter int         SYNC_STAGES = 2,
   localparam int        IDX_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_oe_o,
   input  logic [2:0]            strap_i,
   output logic [NUM_REGS*8-1:0] cfg_o
);

   generate
      if (NUM_REGS < 1 || NUM_REGS > 127) begin : g_bad_regs
         $error("cfgbus_i2c_slave: NUM_REGS out of range");
      end
      if (RO_IDX < 0 || RO_IDX >= NUM_REGS) begin : g_bad_ro
         $error("cfgbus_i2c_slave: RO_IDX must name an existing byte");
      end
   endgenerate

   logic             scl_lvl, scl_rise, scl_fall;
   logic             sda_lvl, sda_rise, sda_fall;
   logic [7:0]       rd_data;
   logic [IDX_W-1:0] rd_idx;
   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic [7:0]       wr_data;
   bus_state_e       bus_state;

   cfgbus_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i),
      .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

   cfgbus_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i),
      .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

   cfgbus_bus_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
      .rd_data(rd_data), .rd_idx(rd_idx),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .sda_oe(sda_oe_o), .state_o(bus_state));

   cfgbus_reg_bank #(.NUM_REGS(NUM_REGS), .RO_IDX(RO_IDX)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .strap_i(strap_i),
      .rd_data(rd_data), .cfg_o(cfg_o));

endmodule

// File: rtl/cfgbus_i2c_slave_chk.sv
module cfgbus_i2c_slave_chk
   import cfgbus_pkg::*;
#(
   parameter int NUM_REGS = 6,
   parameter int RO_IDX   = 4,
   parameter int IDX_W    = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  scl_i,
   input logic                  sda_oe_o,
   input logic                  wr_en,
   input logic [IDX_W-1:0]      wr_idx,
   input logic [NUM_REGS*8-1:0] cfg_o,
   input bus_state_e            bus_state
);

   function automatic logic [NUM_REGS*8-1:0] rw_mask();
      logic [NUM_REGS*8-1:0] m;
      m = '1;
      m[RO_IDX*8 +: 8] = 8'h00;
      return m;
   endfunction

   localparam logic [NUM_REGS*8-1:0] RW_MASK = rw_mask();

   // R8: the slave moves SDA only during the low phase of SCL
   p_sda_moves_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_o) |-> !scl_i);

   // R4: writable bytes hold unless the protocol engine issues a write
   p_hold_unwritten_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg_o & RW_MASK));

   // R5: a write strobe never points past the last register
   p_write_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_idx) < NUM_REGS));

   // R9: when the engine is idle, SDA is released
   p_idle_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_state == BUS_IDLE) |-> !sda_oe_o);

endmodule

bind cfgbus_i2c_slave cfgbus_i2c_slave_chk #(
   .NUM_REGS(NUM_REGS), .RO_IDX(RO_IDX), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
   .wr_en(wr_en), .wr_idx(wr_idx), .cfg_o(cfg_o), .bus_state(bus_state));

// File: tb/cfgbus_i2c_slave_bench.sv
module cfgbus_i2c_slave_bench;

   localparam int QT = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic [2:0]  strap = 3'b101;
   logic        sda_oe;
   logic [47:0] cfg;
   wire         sda_line = sda_m & ~sda_oe;

   always #2 clk = ~clk;

   cfgbus_i2c_slave u_cfgbus_i2c_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe_o(sda_oe), .strap_i(strap), .cfg_o(cfg));

   int         checks = 0;
   int         fails  = 0;
   logic [7:0] exp_q[$];
   logic [7:0] act_q[$];
   logic [7:0] model [6];
   logic [7:0] wbuf  [8];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wt(QT); scl_m = 1'b1; wt(QT);
      sda_m = 1'b0; wt(QT); scl_m = 1'b0; wt(QT);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wt(QT); scl_m = 1'b1; wt(QT);
      sda_m = 1'b1; wt(2*QT);
   endtask

   task automatic put_bit(input bit b);
      sda_m = b; wt(QT); scl_m = 1'b1; wt(2*QT); scl_m = 1'b0; wt(QT);
   endtask

   task automatic get_bit(output bit b);
      sda_m = 1'b1; wt(QT); scl_m = 1'b1; wt(QT);
      b = sda_line; wt(QT); scl_m = 1'b0; wt(QT);
   endtask

   task automatic put_byte(input logic [7:0] v, output bit nak);
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(nak);
   endtask

   task automatic get_byte(output logic [7:0] v, input bit master_nak);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(master_nak);
   endtask

   // command 0x5A and length 0x01 are deliberately unrelated to the data
   task automatic wr_txn(input logic [7:0] addr, input int n, input bit stop_after,
                         output bit anak, output int dnak);
      bit b;
      dnak = 0;
      bus_start();
      put_byte(addr, anak);
      if (anak) begin
         bus_stop();
         return;
      end
      put_byte(8'h5A, b); dnak += int'(b);
      put_byte(8'h01, b); dnak += int'(b);
      for (int i = 0; i < n; i++) begin
         put_byte(wbuf[i], b);
         dnak += int'(b);
      end
      if (stop_after) bus_stop();
   endtask

   // driver: pushes expected bytes, then pushes what it receives
   task automatic rd_txn(input int nregs, output bit anak);
      logic [7:0] v;
      bus_start();
      put_byte(8'hD3, anak);
      if (anak) begin
         bus_stop();
         return;
      end
      exp_q.push_back(8'd6);
      for (int i = 0; i < nregs; i++) exp_q.push_back(model[i]);
      for (int i = 0; i <= nregs; i++) begin
         get_byte(v, i == nregs);
         act_q.push_back(v);
      end
   endtask

   task automatic check_cfg(input string tag);
      for (int i = 0; i < 6; i++)
         chk(cfg[i*8 +: 8] == model[i], tag, {24'd0, cfg[i*8 +: 8]}, {24'd0, model[i]});
   endtask

   // monitor: scoreboard for read data (R8)
   initial begin
      forever begin
         logic [7:0] a, e;
         wait (act_q.size() > 0);
         a = act_q.pop_front();
         e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hXX;
         chk(a === e, "R8 read byte", {24'd0, a}, {24'd0, e});
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      bit anak;
      bit b;
      int dnak;
      wt(5);
      rst_n = 1'b1;
      wt(5);

      // R6 R7 R11: power-up contents, straps 101 give byte 4 = 0xDD
      model = '{8'h20, 8'hFF, 8'hFF, 8'hFF, 8'hDD, 8'hFF};
      check_cfg("R6 R7 R11 reset");

      // R2 R3 R4: three data bytes, length byte says 1 and command 0x5A
      wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
      wr_txn(8'hD2, 3, 1'b1, anak, dnak);
      chk(anak == 1'b0, "R1 write address ack", {31'd0, anak}, 0);
      chk(dnak == 0, "R2 R3 header and data acks", dnak, 0);
      wt(4);
      model[0] = 8'hA1; model[1] = 8'hB2; model[2] = 8'hC3;
      check_cfg("R2 R3 R4 partial write");

      // R5: eight data bytes, byte 4 and bytes past 5 are dropped
      for (int i = 0; i < 8; i++) wbuf[i] = 8'h10 + 8'(i);
      wr_txn(8'hD2, 8, 1'b1, anak, dnak);
      chk(dnak == 0, "R5 overflow bytes acked", dnak, 0);
      wt(4);
      model[0] = 8'h10; model[1] = 8'h11; model[2] = 8'h12;
      model[3] = 8'h13; model[5] = 8'h15;
      check_cfg("R5 overflow and read-only byte");

      // R1: foreign addresses are not acknowledged
      wr_txn(8'hA0, 0, 1'b1, anak, dnak);
      chk(anak == 1'b1, "R1 foreign address 0xA0 nak", {31'd0, anak}, 1);
      wr_txn(8'hD0, 0, 1'b1, anak, dnak);
      chk(anak == 1'b1, "R1 foreign address 0xD0 nak", {31'd0, anak}, 1);
      check_cfg("R1 no change after foreign address");

      // R8: full read
      rd_txn(6, anak);
      chk(anak == 1'b0, "R1 read address ack", {31'd0, anak}, 0);
      wt(4);
      chk(sda_oe == 1'b0, "R9 released after final nak", {31'd0, sda_oe}, 0);
      bus_stop();
      wait (act_q.size() == 0);

      // R9: early nak after byte 1, then an extra clock sees a free line
      rd_txn(2, anak);
      wt(4);
      chk(sda_oe == 1'b0, "R9 released after early nak", {31'd0, sda_oe}, 0);
      get_bit(b);
      chk(b == 1'b1, "R9 line stays high after nak", {31'd0, b}, 1);
      bus_stop();
      wait (act_q.size() == 0);

      // R10: repeated start restarts at byte 0
      wbuf[0] = 8'h77; wbuf[1] = 8'h88;
      wr_txn(8'hD2, 2, 1'b0, anak, dnak);
      wbuf[0] = 8'h99;
      wr_txn(8'hD2, 1, 1'b1, anak, dnak);
      chk(dnak == 0, "R10 acks after repeated start", dnak, 0);
      wt(4);
      model[0] = 8'h99; model[1] = 8'h88;
      check_cfg("R10 pointer reset on repeated start");

      // R7: straps 010 give byte 4 = 0xF7, also visible in a read
      strap = 3'b010;
      wt(4);
      model[4] = 8'hF7;
      check_cfg("R7 strap view");
      rd_txn(6, anak);
      bus_stop();
      wait (act_q.size() == 0);
      chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule